// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block orders the reset and wake-up events of a small processor subsystem. A single divider chain times all of its delays. The chain advances on the falling edge of the internal oscillator clock, and its top stage doubles as the clock for a watchdog. When an internal reset source fires, the block drives the external reset pin low for a long hold interval. It then keeps the CPU and memories in reset for a short release interval, and after that it enables the bus clocks.

When leaving a low-power stop state, the same chain sets the oscillator settle time before the bus clocks come back. An option bit selects a long or a short settle time. A four-bit status register records which kind of reset occurred last, and it clears on read.

All inputs are plain control levels or strobes sampled on the falling clock edge, and all outputs are registered or decoded from registers. No data path is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `rst_stop_seq`

## Requirements
- R1: When `pwr_on` is released, the block runs its reset sequence from the next falling edge of `clk`. For 4096 falling edges `pin_pull_low` and `core_rst` are both 1. `pin_pull_low` then drops, and `core_rst` stays 1 for 64 more falling edges. After that `core_rst` drops and `bus_clk_en` rises. `bus_clk_en` is 0 for the whole sequence.
- R2: A `lvd_req` or `wdog_req` sampled on a falling edge starts the same 4096 + 64 sequence from that edge. Outputs change only on falling edges, so the pin pull-down appears at the first falling edge that samples the request.
- R3: A further internal request that arrives during the hold or release interval restarts the full 4096-edge hold and clears the divider.
- R4: `rst_flags` bit 0 marks power-on, bit 1 low-voltage, bit 2 watchdog and bit 3 external pin. While `pwr_on` is high the flags read 4'b0001 and all other flags are cleared. A low-voltage or watchdog request sets its own bit.
- R5: A `stat_rd` strobe sampled on a falling edge clears all flags at that edge. An event sampled on the same edge still sets its bit.
- R6: A `stop_req` sampled while running drops `bus_clk_en` at that edge, clears the divider and holds it at zero until a wake.
- R7: A wake (`wake_req` high, or `ext_rst_n` low) in stop holds `bus_clk_en` low for 4096 falling edges if `short_wake` is 0 at the wake edge, or for 32 falling edges if it is 1. Later changes of `short_wake` have no effect on that wake.
- R8: `ext_rst_n` low sets flag bit 3 (outside the hold interval) and asserts `core_rst` from the next falling edge while low. It never drives `pin_pull_low` and never disturbs the divider, which keeps `wdog_clk` on its free-running phase.
- R9: `wdog_clk` is bit 12 of the 13-stage divider. It is a square wave with a period of 8192 falling edges while the divider runs, and it restarts from low whenever the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock; the block uses its falling edge |
| pwr_on | input | 1 | Asynchronous power-on reset, active high |
| lvd_req | input | 1 | Low-voltage reset request |
| wdog_req | input | 1 | Watchdog reset request |
| ext_rst_n | input | 1 | Level driven onto the reset pin from outside, active low |
| stop_req | input | 1 | Stop-entry strobe |
| wake_req | input | 1 | Wake event (interrupt or break) |
| short_wake | input | 1 | 1 selects the short stop-recovery delay |
| stat_rd | input | 1 | Read strobe for the status flags |
| pin_pull_low | output | 1 | Drives the reset pin low |
| core_rst | output | 1 | Reset to CPU and memories |
| bus_clk_en | output | 1 | Bus clock enable |
| wdog_clk | output | 1 | Divided clock to the watchdog |
| rst_flags | output | 4 | Reset status flags |

## Verification
The bench targets the interval boundaries: the 4096th and 64th edges of the sequence and the 32nd edge of a short wake. An off-by-one compare there would move `pin_pull_low`, `core_rst` or `bus_clk_en` by a cycle. A second request during the hold tests the restart rule; a design that ignored it would release the pin early. It also tests `short_wake` changing just after the wake edge, which a design that does not latch the option would follow. An external pin pulse is checked against the `wdog_clk` phase, since a design that cleared the divider there would shift that phase. A read that coincides with a watchdog request tests set-over-clear priority.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    PH_HOLD = 3'd0,
    PH_REL  = 3'd1,
    PH_RUN  = 3'd2,
    PH_STOP = 3'd3,
    PH_WAKE = 3'd4
  } phase_t;

  localparam int FLG_N   = 4;
  localparam int FLG_PWR = 0;
  localparam int FLG_LV  = 1;
  localparam int FLG_WD  = 2;
  localparam int FLG_EXT = 3;
endpackage

// File: rtl/rsq_divider.sv
module rsq_divider #(
  parameter int STAGES = 12
) (
  input  logic              clk,
  input  logic              pwr_on,
  input  logic              clr,
  input  logic              frz,
  output logic [STAGES:0]   cnt,
  output logic              tick_clk
);
  // counting stages plus one top stage; the low stages wrap into the top one
  always_ff @(negedge clk or posedge pwr_on) begin
    if (pwr_on)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (!frz)   cnt <= cnt + 1'b1;
  end

  assign tick_clk = cnt[STAGES];
endmodule

// File: rtl/rsq_phase_ctl.sv
module rsq_phase_ctl
  import rsq_pkg::*;
#(
  parameter int STAGES    = 12,
  parameter int REL_CYC   = 64,
  parameter int SHORT_CYC = 32
) (
  input  logic              clk,
  input  logic              pwr_on,
  input  logic              int_req,
  input  logic              stop_req,
  input  logic              wake_any,
  input  logic              short_wake,
  input  logic [STAGES-1:0] low_cnt,
  output phase_t            phase,
  output logic              cnt_clr,
  output logic              cnt_frz
);
  localparam logic [STAGES-1:0] LONG_LAST  = '1;
  localparam logic [STAGES-1:0] REL_LAST   = STAGES'(REL_CYC - 1);
  localparam logic [STAGES-1:0] SHORT_LAST = STAGES'(SHORT_CYC - 1);

  phase_t nxt;
  logic   short_q, short_nxt;
  logic [STAGES-1:0] wake_last;

  assign wake_last = short_q ? SHORT_LAST : LONG_LAST;

  always_comb begin
    nxt       = phase;
    short_nxt = short_q;
    cnt_clr   = 1'b0;
    cnt_frz   = 1'b0;
    if (int_req) begin
      nxt     = PH_HOLD;
      cnt_clr = 1'b1;
    end else begin
      unique case (phase)
        PH_HOLD: if (low_cnt == LONG_LAST) begin
          nxt     = PH_REL;
          cnt_clr = 1'b1;
        end
        PH_REL:  if (low_cnt == REL_LAST) nxt = PH_RUN;
        PH_RUN:  if (stop_req) begin
          nxt     = PH_STOP;
          cnt_clr = 1'b1;
        end
        PH_STOP: begin
          cnt_frz = 1'b1;
          if (wake_any) begin
            nxt       = PH_WAKE;
            short_nxt = short_wake;
          end
        end
        PH_WAKE: if (low_cnt == wake_last) nxt = PH_RUN;
        default: begin
          nxt     = PH_HOLD;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(negedge clk or posedge pwr_on) begin
    if (pwr_on) begin
      phase   <= PH_HOLD;
      short_q <= 1'b0;
    end else begin
      phase   <= nxt;
      short_q <= short_nxt;
    end
  end
endmodule

// File: rtl/rsq_status.sv
module rsq_status
  import rsq_pkg::*;
#(
  parameter int N = FLG_N
) (
  input  logic         clk,
  input  logic         pwr_on,
  input  logic         rd,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;
    always_ff @(negedge clk or posedge pwr_on) begin
      if (pwr_on)      bit_q <= (i == FLG_PWR);
      else if (set[i]) bit_q <= 1'b1;
      else if (rd)     bit_q <= 1'b0;
    end
    assign flags[i] = bit_q;
  end
endmodule

// File: rtl/rst_stop_seq.sv
module rst_stop_seq
  import rsq_pkg::*;
#(
  parameter int STAGES    = 12,
  parameter int REL_CYC   = 64,
  parameter int SHORT_CYC = 32
) (
  input  logic             clk,
  input  logic             pwr_on,
  input  logic             lvd_req,
  input  logic             wdog_req,
  input  logic             ext_rst_n,
  input  logic             stop_req,
  input  logic             wake_req,
  input  logic             short_wake,
  input  logic             stat_rd,
  output logic             pin_pull_low,
  output logic             core_rst,
  output logic             bus_clk_en,
  output logic             wdog_clk,
  output logic [FLG_N-1:0] rst_flags
);
  logic [STAGES:0] cnt;
  logic            cnt_clr, cnt_frz;
  logic            int_req, wake_any, ext_q;
  phase_t          phase;
  logic [FLG_N-1:0] flag_set;

  assign int_req  = lvd_req | wdog_req;
  assign wake_any = wake_req | ~ext_rst_n;

  rsq_divider #(.STAGES(STAGES)) u_div (
    .clk      (clk),
    .pwr_on   (pwr_on),
    .clr      (cnt_clr),
    .frz      (cnt_frz),
    .cnt      (cnt),
    .tick_clk (wdog_clk)
  );

  rsq_phase_ctl #(
    .STAGES(STAGES), .REL_CYC(REL_CYC), .SHORT_CYC(SHORT_CYC)
  ) u_ctl (
    .clk        (clk),
    .pwr_on     (pwr_on),
    .int_req    (int_req),
    .stop_req   (stop_req),
    .wake_any   (wake_any),
    .short_wake (short_wake),
    .low_cnt    (cnt[STAGES-1:0]),
    .phase      (phase),
    .cnt_clr    (cnt_clr),
    .cnt_frz    (cnt_frz)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_LV]  = lvd_req;
    flag_set[FLG_WD]  = wdog_req;
    flag_set[FLG_EXT] = ~ext_rst_n & (phase != PH_HOLD);
  end

  rsq_status #(.N(FLG_N)) u_stat (
    .clk    (clk),
    .pwr_on (pwr_on),
    .rd     (stat_rd),
    .set    (flag_set),
    .flags  (rst_flags)
  );

  // external pin level sampled for the core reset; the divider is left alone
  always_ff @(negedge clk or posedge pwr_on) begin
    if (pwr_on) ext_q <= 1'b0;
    else        ext_q <= ~ext_rst_n;
  end

  assign pin_pull_low = (phase == PH_HOLD);
  assign core_rst     = (phase == PH_HOLD) | (phase == PH_REL) | ext_q;
  assign bus_clk_en   = (phase == PH_RUN);
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int STAGES = 12
) (
  input logic       clk,
  input logic       pwr_on,
  input logic       lvd_req,
  input logic       wdog_req,
  input logic       ext_rst_n,
  input logic       stop_req,
  input logic       stat_rd,
  input logic       pin_pull_low,
  input logic       core_rst,
  input logic       bus_clk_en,
  input logic [3:0] rst_flags
);
  localparam int HOLD_CYC = 1 << STAGES;

  logic [STAGES+1:0] hold_run;

  always_ff @(negedge clk or posedge pwr_on) begin
    if (pwr_on)                    hold_run <= '0;
    else if (lvd_req || wdog_req)  hold_run <= '0;
    else if (pin_pull_low)         hold_run <= hold_run + 1'b1;
    else                           hold_run <= '0;
  end

  a_r1_pin_implies_core: assert property (@(negedge clk) disable iff (pwr_on)
    pin_pull_low |-> core_rst);

  a_r1_hold_len: assert property (@(negedge clk) disable iff (pwr_on)
    pin_pull_low |-> (hold_run < HOLD_CYC));

  a_r1_bus_off_in_hold: assert property (@(negedge clk) disable iff (pwr_on)
    bus_clk_en |-> !pin_pull_low);

  a_r2_req_pulls_pin: assert property (@(negedge clk) disable iff (pwr_on)
    (lvd_req || wdog_req) |=> pin_pull_low);

  a_r4_lv_flag: assert property (@(negedge clk) disable iff (pwr_on)
    lvd_req |=> rst_flags[1]);

  a_r5_read_clears: assert property (@(negedge clk) disable iff (pwr_on)
    (stat_rd && !lvd_req && !wdog_req && ext_rst_n) |=> (rst_flags == 4'b0000));

  a_r6_stop_gates_bus: assert property (@(negedge clk) disable iff (pwr_on)
    (bus_clk_en && stop_req && !lvd_req && !wdog_req) |=> !bus_clk_en);

  a_r8_ext_core: assert property (@(negedge clk) disable iff (pwr_on)
    !ext_rst_n |=> core_rst);
endmodule

bind rst_stop_seq rsq_checker #(.STAGES(STAGES)) u_chk (
  .clk          (clk),
  .pwr_on       (pwr_on),
  .lvd_req      (lvd_req),
  .wdog_req     (wdog_req),
  .ext_rst_n    (ext_rst_n),
  .stop_req     (stop_req),
  .stat_rd      (stat_rd),
  .pin_pull_low (pin_pull_low),
  .core_rst     (core_rst),
  .bus_clk_en   (bus_clk_en),
  .rst_flags    (rst_flags)
);

// File: tb/rst_stop_seq_bench.sv
module rst_stop_seq_bench;
  logic clk = 1'b0;
  logic pwr_on = 1'b0, lvd_req = 1'b0, wdog_req = 1'b0, ext_rst_n = 1'b1;
  logic stop_req = 1'b0, wake_req = 1'b0, short_wake = 1'b0, stat_rd = 1'b0;
  logic pin_pull_low, core_rst, bus_clk_en, wdog_clk;
  logic [3:0] rst_flags;

  int n_tests = 0, n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string tag = "R4";

  always #5 clk = ~clk;

  rst_stop_seq u_rst_stop_seq (
    .clk(clk), .pwr_on(pwr_on), .lvd_req(lvd_req), .wdog_req(wdog_req),
    .ext_rst_n(ext_rst_n), .stop_req(stop_req), .wake_req(wake_req),
    .short_wake(short_wake), .stat_rd(stat_rd), .pin_pull_low(pin_pull_low),
    .core_rst(core_rst), .bus_clk_en(bus_clk_en), .wdog_clk(wdog_clk),
    .rst_flags(rst_flags)
  );

  // behavioural reference: 0 hold, 1 release, 2 run, 3 stop, 4 wake
  int m_mode, m_cnt, m_lim;
  logic [3:0] m_flags;
  bit m_ext;

  always @(negedge clk or posedge pwr_on) begin
    if (pwr_on) begin
      m_mode = 0; m_cnt = 0; m_lim = 4096; m_flags = 4'b0001; m_ext = 0;
    end else begin
      logic [3:0] nf;
      nf = stat_rd ? 4'b0000 : m_flags;
      if (lvd_req) nf[1] = 1'b1;
      if (wdog_req) nf[2] = 1'b1;
      if (!ext_rst_n && m_mode != 0) nf[3] = 1'b1;
      m_flags = nf;
      m_ext = !ext_rst_n;
      if (lvd_req || wdog_req) begin
        m_mode = 0; m_cnt = 0;
      end else begin
        case (m_mode)
          0: if (m_cnt == 4095) begin m_mode = 1; m_cnt = 0; end
             else m_cnt = (m_cnt + 1) % 8192;
          1: begin if (m_cnt == 63) m_mode = 2; m_cnt = (m_cnt + 1) % 8192; end
          2: if (stop_req) begin m_mode = 3; m_cnt = 0; end
             else m_cnt = (m_cnt + 1) % 8192;
          3: if (wake_req || !ext_rst_n) begin
               m_mode = 4; m_lim = short_wake ? 32 : 4096;
             end
          default: begin
            if (m_cnt == m_lim - 1) m_mode = 2;
            m_cnt = (m_cnt + 1) % 8192;
          end
        endcase
      end
    end
  end

  function automatic logic [7:0] expected();
    logic pin, core, bus, wd;
    pin  = (m_mode == 0);
    core = (m_mode == 0) || (m_mode == 1) || m_ext;
    bus  = (m_mode == 2);
    wd   = (m_cnt >= 4096);
    return {pin, core, bus, wd, m_flags};
  endfunction

  function automatic logic [7:0] actual();
    return {pin_pull_low, core_rst, bus_clk_en, wdog_clk, rst_flags};
  endfunction

  task automatic chk(string t, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pin,core,bus,wd,flags} actual %b expected %b at %0t",
               t, act, exp, $time);
    end
  endtask

  // compare against the reference on every rising edge (outputs move on falling)
  always @(posedge clk) begin
    if (chk_on && !pwr_on && !done) chk(tag, actual(), expected());
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 pwr_on = 1'b1;
    step(2);
    // R4: reset state
    chk("R4", actual(), 8'b1100_0001);
    chk_on = 1'b1;
    pwr_on = 1'b0;

    tag = "R1"; step(4300);
    chk("R1", {pin_pull_low, core_rst, bus_clk_en}, 8'b0000_0001);

    tag = "R5"; stat_rd = 1'b1; step(1); stat_rd = 1'b0; step(4);

    // R2: request acts at the next falling edge, not before
    tag = "R2"; lvd_req = 1'b1; #2;
    chk("R2", {7'd0, pin_pull_low}, 8'd0);
    step(1); lvd_req = 1'b0;
    chk("R2", {7'd0, pin_pull_low}, 8'd1);
    step(1000);

    tag = "R3"; wdog_req = 1'b1; step(1); wdog_req = 1'b0;
    step(3500);
    chk("R3", {7'd0, pin_pull_low}, 8'd1);
    step(800);

    tag = "R5"; stat_rd = 1'b1; step(1); stat_rd = 1'b0; step(5);
    stat_rd = 1'b1; wdog_req = 1'b1; step(1); stat_rd = 1'b0; wdog_req = 1'b0;
    chk("R5", {4'd0, rst_flags}, 8'b0000_0100);
    step(4300);

    tag = "R9"; step(9000);

    tag = "R8"; ext_rst_n = 1'b0; step(10); ext_rst_n = 1'b1; step(20);

    tag = "R6"; stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R6", {7'd0, bus_clk_en}, 8'd0);
    step(50);

    tag = "R7"; short_wake = 1'b0; wake_req = 1'b1; step(1); wake_req = 1'b0;
    step(4200);
    stop_req = 1'b1; step(1); stop_req = 1'b0; step(20);
    short_wake = 1'b1; wake_req = 1'b1; step(1); wake_req = 1'b0; short_wake = 1'b0;
    step(40);
    chk("R7", {7'd0, bus_clk_en}, 8'd1);
    step(60);

    tag = "R8"; stop_req = 1'b1; step(1); stop_req = 1'b0; step(20);
    ext_rst_n = 1'b0; step(3); ext_rst_n = 1'b1; step(4200);

    tag = "R4"; lvd_req = 1'b1; step(1); lvd_req = 1'b0; step(10);
    pwr_on = 1'b1; step(2);
    chk("R4", actual(), 8'b1100_0001);
    pwr_on = 1'b0; step(4300);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule